// File: doc/BRIEF.md
# Decoded Micro-op Window Cache

This block keeps the micro-ops produced by an instruction decoder so that a front end can replay them without decoding again. Code is grouped into aligned 32-byte windows of virtual address space. A window is stored as one to three lines of up to six micro-ops each, all placed in the same set of an 8-way, 32-set array. Lookups use the virtual address directly, so no translation sits between request and hit.

A fill presents one window as a stream of instruction beats. Each beat carries that instruction's micro-op count, its micro-ops and a flag that marks an unconditional or predicted-taken branch. The block packs the beats into lines, commits the finished window to the array, and evicts whole resident windows when the set has no room. If the window breaks a placement rule, the block leaves the array untouched and pulses a reject flag. A lookup returns a hit or miss the cycle after it is accepted and then streams the window one line per cycle. A window can be invalidated by address to keep the block inclusive of the instruction cache or to follow a translation shootdown, and a flush empties the whole array.

Top module: `uop_window_cache`

## Requirements
- R1: The set is chosen by virtual address bits [9:5] and the tag is bits [31:10]. Any address inside an aligned 32-byte window finds that window, and a window with another tag that maps to the same set does not.
- R2: A line holds at most 6 micro-ops. The micro-ops of one instruction are never split across two lines, so an instruction that does not fit in the current line opens a new one. A hit delivers the micro-ops in fill order.
- R3: A window that needs more than 3 lines is rejected. fill_reject pulses for one cycle, fill_done does not, the array is unchanged, and a copy of that window that was already resident still hits with its old content. No window ever holds more than 3 ways.
- R4: A beat with fill_taken set closes its line, and the next instruction starts a new line even if slots remain free.
- R5: A beat whose micro-op count is 0 or greater than 6 causes the whole window to be rejected.
- R6: A lookup is accepted when lk_valid and lk_ready are both high. On the next cycle out_valid rises with out_line 0. A hit then delivers one line per cycle with out_line counting up, and out_last marks the final line. A miss is a single beat with out_hit low and out_last high.
- R7: Filling a window that is already resident replaces the old copy completely.
- R8: When a set lacks free ways, the block evicts the window that owns the pseudo-LRU victim way, taking all of its ways together, until the new window fits. A window that was hit recently stays resident.
- R9: An invalidation makes exactly the addressed window miss. Other windows in the same set keep hitting.
- R10: A flush makes every window miss.
- R11: After reset, every lookup misses, out_valid, fill_done and fill_reject are low, and fill_ready and lk_ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Instruction beat present |
| fill_first | input | 1 | Beat is the first of a window |
| fill_last | input | 1 | Beat is the last of a window |
| fill_va | input | 32 | Window virtual address, used on the first beat |
| fill_nuops | input | 3 | Micro-op count of this instruction |
| fill_taken | input | 1 | Instruction is an unconditional or predicted-taken branch |
| fill_uops | input | 48 | Micro-ops; slot s in bits [8s+7:8s] |
| fill_ready | output | 1 | Fill beats may be sent |
| fill_done | output | 1 | One-cycle pulse: window written to the array |
| fill_reject | output | 1 | One-cycle pulse: window refused |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_ready | output | 1 | Lookup may be accepted |
| out_valid | output | 1 | Response beat valid |
| out_hit | output | 1 | Window found |
| out_last | output | 1 | Final beat of the response |
| out_line | output | 2 | Line number within the window |
| out_cnt | output | 3 | Micro-ops in this line |
| out_uops | output | 48 | Micro-ops of this line |
| inv_valid | input | 1 | Invalidate a window |
| inv_va | input | 32 | Address of the window to invalidate |
| flush | input | 1 | Invalidate all windows |

## Verification
On every cycle, the assertions check the response sequencing: a response the cycle after acceptance, lines stepping by one, single-beat misses, and line counts within 1 to 6. They also check that a commit never leaves more than the planned ways for its window and never exceeds three, and that a rejection never queues a commit. Only the bench's scenarios can show how instructions are packed into lines, which windows a replacement evicts, that a rejected fill leaves an older copy intact, and that invalidation and flush affect exactly the intended windows.

// File: rtl/uop_window_cache.sv
module uop_window_cache #(
  parameter int VAW    = 32,
  parameter int UW     = 8,
  parameter int SETS   = 32,
  parameter int WAYS   = 8,
  parameter int SLOTS  = 6,
  parameter int WLINES = 3,
  parameter int WINB   = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fill_valid,
  input  logic                           fill_first,
  input  logic                           fill_last,
  input  logic [VAW-1:0]                 fill_va,
  input  logic [$clog2(SLOTS+1)-1:0]     fill_nuops,
  input  logic                           fill_taken,
  input  logic [SLOTS*UW-1:0]            fill_uops,
  output logic                           fill_ready,
  output logic                           fill_done,
  output logic                           fill_reject,
  input  logic                           lk_valid,
  input  logic [VAW-1:0]                 lk_va,
  output logic                           lk_ready,
  output logic                           out_valid,
  output logic                           out_hit,
  output logic                           out_last,
  output logic [$clog2(WLINES)-1:0]      out_line,
  output logic [$clog2(SLOTS+1)-1:0]     out_cnt,
  output logic [SLOTS*UW-1:0]            out_uops,
  input  logic                           inv_valid,
  input  logic [VAW-1:0]                 inv_va,
  input  logic                           flush
);
  localparam int SB  = $clog2(SETS);
  localparam int WB  = $clog2(WAYS);
  localparam int TW  = VAW - WINB - SB;
  localparam int CW  = $clog2(SLOTS+1);
  localparam int SIW = $clog2(SLOTS);
  localparam int LIW = $clog2(WLINES);
  localparam int LNW = $clog2(WLINES+1);
  localparam int ENT = SETS*WAYS;

  typedef enum logic [1:0] {S_IDLE, S_COMMIT, S_DELIVER} st_t;
  st_t st;

  logic [SLOTS*UW-1:0] dat   [ENT];
  logic [CW-1:0]       cnt_q [ENT];
  logic [TW-1:0]       tag_q [ENT];
  logic [LIW-1:0]      lno_q [ENT];
  logic [ENT-1:0]      vld_q;
  logic [WAYS-2:0]     plru_q [SETS];

  function automatic logic [WB-1:0] plru_victim(input logic [WAYS-2:0] b);
    int idx;
    logic [WB-1:0] v;
    idx = 0;
    v = '0;
    for (int l = 0; l < WB; l++) begin
      v[WB-1-l] = b[idx];
      idx = 2*idx + 1 + int'(b[idx]);
    end
    return v;
  endfunction

  function automatic logic [WAYS-2:0] plru_touch(input logic [WAYS-2:0] b, input logic [WB-1:0] w);
    int idx;
    logic d;
    idx = 0;
    for (int l = 0; l < WB; l++) begin
      d = w[WB-1-l];
      b[idx] = ~d;
      idx = 2*idx + 1 + int'(d);
    end
    return b;
  endfunction

  // fill staging
  logic [UW-1:0]  stg     [WLINES][SLOTS];
  logic [CW-1:0]  stg_cnt [WLINES];
  logic [LIW-1:0] cur_q;
  logic           closed_q, bad_q, cm_pend;
  logic [VAW-1:0] cm_va;
  logic [LNW-1:0] cm_need;

  assign fill_ready = !cm_pend;
  wire beat = fill_valid && fill_ready;

  logic [CW-1:0]  b_cnt, pos;
  logic [LIW-1:0] b_cur;
  logic           b_cl, b_bad, need_new, beat_bad;
  logic [LIW:0]   nc_w;

  always_comb begin
    b_cnt    = fill_first ? '0 : stg_cnt[cur_q];
    b_cur    = fill_first ? '0 : cur_q;
    b_cl     = !fill_first && closed_q;
    b_bad    = !fill_first && bad_q;
    need_new = b_cl || (int'(b_cnt) + int'(fill_nuops) > SLOTS);
    nc_w     = {1'b0, b_cur} + (LIW+1)'(need_new);
    beat_bad = (fill_nuops == '0) || (int'(fill_nuops) > SLOTS) || (int'(nc_w) >= WLINES);
    pos      = need_new ? '0 : b_cnt;
  end

  wire beat_ok = beat && !b_bad && !beat_bad;
  logic cm_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q       <= '0;
      closed_q    <= 1'b0;
      bad_q       <= 1'b0;
      cm_pend     <= 1'b0;
      fill_reject <= 1'b0;
      cm_need     <= '0;
      cm_va       <= '0;
      for (int l = 0; l < WLINES; l++) stg_cnt[l] <= '0;
    end else begin
      fill_reject <= 1'b0;
      if (beat) begin
        if (fill_first) begin
          cm_va <= fill_va;
          for (int l = 0; l < WLINES; l++) stg_cnt[l] <= '0;
        end
        bad_q <= b_bad || beat_bad;
        if (beat_ok) begin
          cur_q    <= nc_w[LIW-1:0];
          closed_q <= fill_taken;
          stg_cnt[nc_w[LIW-1:0]] <= pos + fill_nuops;
        end
        if (fill_last) begin
          if (b_bad || beat_bad) fill_reject <= 1'b1;
          else begin
            cm_pend <= 1'b1;
            cm_need <= LNW'(nc_w + 1'b1);
          end
        end
      end
      if (cm_done) cm_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (beat_ok)
      for (int s = 0; s < SLOTS; s++)
        if (s < int'(fill_nuops))
          stg[nc_w[LIW-1:0]][SIW'(int'(pos) + s)] <= fill_uops[s*UW +: UW];
  end

  // commit planning
  wire [SB-1:0] cm_set = cm_va[WINB +: SB];
  wire [TW-1:0] cm_tag = cm_va[VAW-1 -: TW];
  logic [WAYS-1:0] c_mt, c_fr, c_ev, c_al;
  logic [LIW-1:0]  c_lno [WAYS];
  logic [WB-1:0]   c_a0, c_pv, c_vic;
  logic [TW-1:0]   c_vtag;
  logic            c_enough;

  always_comb begin
    int k;
    k    = 0;
    c_a0 = '0;
    for (int w = 0; w < WAYS; w++) begin
      c_mt[w]  = vld_q[{cm_set, WB'(w)}] && (tag_q[{cm_set, WB'(w)}] == cm_tag);
      c_fr[w]  = !vld_q[{cm_set, WB'(w)}];
      c_al[w]  = 1'b0;
      c_lno[w] = '0;
      if (c_fr[w] && k < int'(cm_need)) begin
        c_al[w]  = 1'b1;
        c_lno[w] = LIW'(k);
        if (k == 0) c_a0 = WB'(w);
        k++;
      end
    end
    c_enough = $countones(c_fr) >= int'(cm_need);
    c_pv  = plru_victim(plru_q[cm_set]);
    c_vic = c_pv;
    if (!vld_q[{cm_set, c_pv}])
      for (int w = WAYS-1; w >= 0; w--)
        if (vld_q[{cm_set, WB'(w)}]) c_vic = WB'(w);
    c_vtag = tag_q[{cm_set, c_vic}];
    for (int w = 0; w < WAYS; w++)
      c_ev[w] = vld_q[{cm_set, WB'(w)}] && (tag_q[{cm_set, WB'(w)}] == c_vtag);
  end

  assign cm_done = (st == S_COMMIT) && !(|c_mt) && c_enough;

  // lookup
  wire [SB-1:0] lk_set = lk_va[WINB +: SB];
  wire [TW-1:0] lk_tag = lk_va[VAW-1 -: TW];
  logic [WAYS-1:0] l_mt;
  logic [WB-1:0]   l_way [WLINES];
  logic            l_hit;

  always_comb begin
    l_hit = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      l_mt[w] = vld_q[{lk_set, WB'(w)}] && (tag_q[{lk_set, WB'(w)}] == lk_tag);
      if (l_mt[w] && lno_q[{lk_set, WB'(w)}] == '0) l_hit = 1'b1;
    end
    for (int k = 0; k < WLINES; k++) begin
      l_way[k] = '0;
      for (int w = 0; w < WAYS; w++)
        if (l_mt[w] && int'(lno_q[{lk_set, WB'(w)}]) == k) l_way[k] = WB'(w);
    end
  end

  assign lk_ready = (st == S_IDLE) && !cm_pend;
  wire lk_go = lk_valid && lk_ready;

  logic [SB-1:0]  dl_set;
  logic [WB-1:0]  dl_way [WLINES];
  logic [LNW-1:0] dl_n;
  logic [LIW-1:0] dl_k;
  logic           dl_hit;

  wire [SB-1:0] inv_set = inv_va[WINB +: SB];
  wire [TW-1:0] inv_tag = inv_va[VAW-1 -: TW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vld_q     <= '0;
      fill_done <= 1'b0;
      dl_set    <= '0;
      dl_n      <= '0;
      dl_k      <= '0;
      dl_hit    <= 1'b0;
      for (int k = 0; k < WLINES; k++) dl_way[k] <= '0;
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else begin
      fill_done <= cm_done;
      case (st)
        S_IDLE: begin
          if (cm_pend) st <= S_COMMIT;
          else if (lk_go) begin
            st     <= S_DELIVER;
            dl_set <= lk_set;
            dl_hit <= l_hit;
            dl_n   <= LNW'($countones(l_mt));
            dl_k   <= '0;
            for (int k = 0; k < WLINES; k++) dl_way[k] <= l_way[k];
            if (l_hit) plru_q[lk_set] <= plru_touch(plru_q[lk_set], l_way[0]);
          end
        end
        S_COMMIT: begin
          if (|c_mt) begin
            for (int w = 0; w < WAYS; w++) if (c_mt[w]) vld_q[{cm_set, WB'(w)}] <= 1'b0;
          end else if (c_enough) begin
            for (int w = 0; w < WAYS; w++) if (c_al[w]) vld_q[{cm_set, WB'(w)}] <= 1'b1;
            plru_q[cm_set] <= plru_touch(plru_q[cm_set], c_a0);
            st <= S_IDLE;
          end else begin
            for (int w = 0; w < WAYS; w++) if (c_ev[w]) vld_q[{cm_set, WB'(w)}] <= 1'b0;
          end
        end
        S_DELIVER: begin
          if (out_last) st <= S_IDLE;
          else dl_k <= dl_k + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
      if (inv_valid)
        for (int w = 0; w < WAYS; w++)
          if (vld_q[{inv_set, WB'(w)}] && tag_q[{inv_set, WB'(w)}] == inv_tag)
            vld_q[{inv_set, WB'(w)}] <= 1'b0;
      if (flush) vld_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (cm_done)
      for (int w = 0; w < WAYS; w++)
        if (c_al[w]) begin
          tag_q[{cm_set, WB'(w)}] <= cm_tag;
          lno_q[{cm_set, WB'(w)}] <= c_lno[w];
          cnt_q[{cm_set, WB'(w)}] <= stg_cnt[c_lno[w]];
          for (int s = 0; s < SLOTS; s++)
            dat[{cm_set, WB'(w)}][s*UW +: UW] <= stg[c_lno[w]][s];
        end
  end

  wire [WB-1:0] cur_way = dl_way[dl_k];
  assign out_valid = (st == S_DELIVER);
  assign out_hit   = dl_hit;
  assign out_line  = dl_k;
  assign out_last  = !dl_hit || (int'(dl_k) == int'(dl_n) - 1);
  assign out_cnt   = dl_hit ? cnt_q[{dl_set, cur_way}] : '0;
  assign out_uops  = dl_hit ? dat[{dl_set, cur_way}] : '0;

  AST_LK_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> out_valid && out_line == '0); // R6
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid && out_line == $past(out_line) + 1'b1); // R6
  AST_MISS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> out_last); // R6
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> out_cnt != '0 && int'(out_cnt) <= SLOTS); // R2
  AST_WIN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> $countones(c_mt) <= WLINES && $countones(c_mt) <= int'(cm_need)); // R3
  AST_REJ_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_reject |-> !cm_pend); // R3
  AST_DONE_XOR_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_done && fill_reject)); // R3
endmodule

// File: tb/tb_uop_window_cache.sv
`timescale 1ns/1ps
module tb_uop_window_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_valid = 0, fill_first = 0, fill_last = 0, fill_taken = 0;
  logic [31:0] fill_va = '0;
  logic [2:0]  fill_nuops = '0;
  logic [47:0] fill_uops = '0;
  logic fill_ready, fill_done, fill_reject;
  logic lk_valid = 0;
  logic [31:0] lk_va = '0;
  logic lk_ready, out_valid, out_hit, out_last;
  logic [1:0] out_line;
  logic [2:0] out_cnt;
  logic [47:0] out_uops;
  logic inv_valid = 0, flush = 0;
  logic [31:0] inv_va = '0;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  uop_window_cache dut (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_first(fill_first), .fill_last(fill_last),
    .fill_va(fill_va), .fill_nuops(fill_nuops), .fill_taken(fill_taken),
    .fill_uops(fill_uops), .fill_ready(fill_ready), .fill_done(fill_done),
    .fill_reject(fill_reject), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_ready(lk_ready), .out_valid(out_valid), .out_hit(out_hit),
    .out_last(out_last), .out_line(out_line), .out_cnt(out_cnt),
    .out_uops(out_uops), .inv_valid(inv_valid), .inv_va(inv_va), .flush(flush)
  );

  // {va[79:48], nins[47:44], counts[43:20] (instr0 lowest), taken[19:12], reject[11], nlines[10:9], l0[8:6], l1[5:3], l2[2:0]}
  localparam logic [79:0] TBL [10] = '{
    {32'h00001000, 4'd3, 24'o222,   8'h00, 1'b0, 2'd1, 9'o600}, // R2 single full line
    {32'h00001020, 4'd2, 24'o34,    8'h00, 1'b0, 2'd2, 9'o430}, // R2 no split
    {32'h00001040, 4'd3, 24'o111,   8'h02, 1'b0, 2'd2, 9'o210}, // R4 taken closes line
    {32'h00001060, 4'd4, 24'o1666,  8'h00, 1'b1, 2'd0, 9'o000}, // R3 four lines
    {32'h00001080, 4'd2, 24'o73,    8'h00, 1'b1, 2'd0, 9'o000}, // R5 seven uops
    {32'h000010A0, 4'd5, 24'o65115, 8'h00, 1'b0, 2'd3, 9'o666}, // R2 three full lines
    {32'h000010C0, 4'd3, 24'o222,   8'h07, 1'b0, 2'd3, 9'o222}, // R4 every line closed
    {32'h000010E0, 4'd2, 24'o02,    8'h00, 1'b1, 2'd0, 9'o000}, // R5 zero uops
    {32'h00001100, 4'd1, 24'o1,     8'h01, 1'b0, 2'd1, 9'o100}, // R4 taken on last
    {32'h00001120, 4'd2, 24'o33,    8'h01, 1'b0, 2'd2, 9'o330}  // R4 taken with room left
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] va, input int nins, input logic [23:0] cnts,
                      input logic [7:0] tkn, input logic [2:0] pid, output bit rej);
    int j;
    j = 0;
    while (!fill_ready) @(negedge clk);
    for (int i = 0; i < nins; i++) begin
      logic [2:0] n;
      n = cnts[i*3 +: 3];
      fill_valid = 1'b1;
      fill_first = (i == 0);
      fill_last  = (i == nins-1);
      fill_va    = va;
      fill_nuops = n;
      fill_taken = tkn[i];
      fill_uops  = '0;
      for (int s = 0; s < 6; s++)
        if (s < int'(n)) fill_uops[s*8 +: 8] = {pid, 5'(j + s)};
      j += int'(n);
      @(negedge clk);
    end
    fill_valid = 1'b0; fill_first = 1'b0; fill_last = 1'b0; fill_taken = 1'b0;
    rej = 1'b0;
    for (int t = 0; t < 60; t++) begin
      if (fill_reject) begin rej = 1'b1; break; end
      if (fill_done) break;
      @(negedge clk);
    end
  endtask

  task automatic look(input logic [31:0] va, input bit exp_hit, input logic [1:0] exp_nl,
                      input logic [8:0] exp_l, input logic [2:0] pid, input string req);
    int j;
    j = 0;
    while (!lk_ready) @(negedge clk);
    lk_valid = 1'b1;
    lk_va = va;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(out_valid && out_line == 2'd0, "R6 response timing", out_valid, 1);
    chk(out_hit == exp_hit, req, out_hit, exp_hit);
    if (!exp_hit || !out_hit) begin
      chk(out_last, "R6 miss single beat", out_last, 1);
      @(negedge clk);
      return;
    end
    for (int k = 0; k < int'(exp_nl); k++) begin
      logic [2:0] ec;
      ec = exp_l[8-3*k -: 3];
      chk(out_valid && int'(out_line) == k, "R6 line order", out_line, k);
      chk(out_cnt == ec, req, out_cnt, ec);
      for (int s = 0; s < int'(ec); s++) begin
        chk(out_uops[s*8 +: 8] == {pid, 5'(j)}, "R2 uop order", out_uops[s*8 +: 8], {pid, 5'(j)});
        j++;
      end
      chk(out_last == (k == int'(exp_nl) - 1), "R6 last flag", out_last, k == int'(exp_nl) - 1);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit rej;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(fill_ready && lk_ready, "R11 ready after reset", {fill_ready, lk_ready}, 3);
    chk(!out_valid && !fill_done && !fill_reject, "R11 quiet after reset",
        {out_valid, fill_done, fill_reject}, 0);
    look(32'h00001000, 1'b0, 2'd0, 9'o0, 3'd0, "R11 empty after reset");

    // table of windows
    for (int i = 0; i < 10; i++) begin
      logic [79:0] e;
      e = TBL[i];
      fill(e[79:48], int'(e[47:44]), e[43:20], e[19:12], 3'(i), rej);
      chk(rej == e[11], "R3 R5 reject flag", rej, e[11]);
      look(e[79:48] + 32'((i*7) % 32), !e[11], e[10:9], e[8:0], 3'(i), "R2 R4 line layout");
    end

    // R1 same set, other tag misses; offset inside window hits
    look(32'h000020A0, 1'b0, 2'd0, 9'o0, 3'd0, "R1 other tag");
    look(32'h000010BF, 1'b1, 2'd3, 9'o666, 3'd5, "R1 window offset");

    // R3 rejected refill keeps old copy
    fill(32'h00001000, 4, 24'o6666, 8'h00, 3'd6, rej);
    chk(rej, "R3 over budget", rej, 1);
    look(32'h00001000, 1'b1, 2'd1, 9'o600, 3'd0, "R3 old copy intact");

    // R7 refill replaces
    fill(32'h00001000, 2, 24'o44, 8'h00, 3'd5, rej);
    chk(!rej, "R7 refill accepted", rej, 0);
    look(32'h00001000, 1'b1, 2'd2, 9'o440, 3'd5, "R7 new content");

    // R8 whole-window eviction in set 20
    fill(32'h00002280, 3, 24'o666, 8'h00, 3'd1, rej);
    fill(32'h00004280, 3, 24'o666, 8'h00, 3'd2, rej);
    fill(32'h00006280, 2, 24'o66,  8'h00, 3'd3, rej);
    look(32'h00002280, 1'b1, 2'd3, 9'o666, 3'd1, "R8 before eviction");
    fill(32'h00008280, 1, 24'o3,   8'h00, 3'd4, rej);
    chk(!rej, "R8 fill into full set", rej, 0);
    look(32'h00004280, 1'b0, 2'd0, 9'o0,   3'd2, "R8 LRU window evicted");
    look(32'h00002280, 1'b1, 2'd3, 9'o666, 3'd1, "R8 recent window kept");
    look(32'h00006280, 1'b1, 2'd2, 9'o660, 3'd3, "R8 other window kept");
    look(32'h00008280, 1'b1, 2'd1, 9'o300, 3'd4, "R8 new window");

    // R9 invalidate one window
    inv_valid = 1'b1; inv_va = 32'h00002285;
    @(negedge clk);
    inv_valid = 1'b0;
    look(32'h00002280, 1'b0, 2'd0, 9'o0,   3'd1, "R9 invalidated");
    look(32'h00006280, 1'b1, 2'd2, 9'o660, 3'd3, "R9 neighbour kept");

    // R10 flush
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    look(32'h000010A0, 1'b0, 2'd0, 9'o0, 3'd5, "R10 flushed");
    look(32'h00008280, 1'b0, 2'd0, 9'o0, 3'd4, "R10 flushed");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule